// File: doc/BRIEF.md
# Single-Wire VPW Bus Idle and Break Detector

This block watches the level of a single-wire variable-pulse-width bus and tells a transmit controller when it may start a frame. It brings the bus level into the local clock domain and finds its edges. It times each active pulse and each passive gap in clock ticks. From those lengths it reports end-of-data, end-of-frame, bus idle and break conditions. A break also produces a one-cycle reset pulse, which returns the surrounding receive and transmit logic to its ready-to-receive state.

Arbitrating nodes use two idle rules. The plain rule declares idle once a passive gap reaches the nominal inter-frame separation. The early rule applies when a gap of at least the minimum end-of-frame length ends in a rising edge. That edge means another node has already judged the bus idle and started its start-of-frame pulse, so a pulse on `early_idle_o` lets a waiting node start in step with it. The early rule is locked out after reset and after any break, until a full inter-frame separation has been counted. Every threshold is a parameter in clock ticks. End-of-data, end-of-frame and break use their nominal value minus a tolerance. Inter-frame separation uses its full nominal value.

Top module: `vpw_idle_brk`

## Requirements
- R1: While `rst_ni` is low, every output is 0. After reset is released, neither idle indication is given until a passive run of IFS_TICKS cycles has been counted. This holds even if a rising edge ends an end-of-frame-length gap before that.
- R2: The bus is active when `bus_i` is 1 and passive when it is 0. `idle_o` rises once the passive run reaches IFS_TICKS. It stays at 1 until a rising edge is detected, and falls in the cycle after that detection.
- R3: A rising edge that ends a passive gap of at least EOF_TICKS-TOL_TICKS and fewer than IFS_TICKS cycles, while the early rule is enabled, gives a single one-cycle pulse on `early_idle_o`.
- R4: A passive gap that starts with a falling edge gives one one-cycle pulse on `eod_o` when it reaches EOD_TICKS-TOL_TICKS cycles.
- R5: A passive gap that starts with a falling edge gives one one-cycle pulse on `eof_o` when it reaches EOF_TICKS-TOL_TICKS cycles.
- R6: An active pulse that reaches BRK_TICKS-TOL_TICKS cycles gives exactly one one-cycle pulse on `brk_o`, however long the pulse lasts.
- R7: `bus_rst_o` pulses for one cycle in exactly the cycles in which `brk_o` pulses.
- R8: After a break, the early rule stays disabled until `idle_o` has been set by a full IFS_TICKS passive run.
- R9: A level change on `bus_i` passes through a two-flop synchronizer. A threshold of N cycles is therefore flagged at the clock edge N+2 edges after the bus changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one timing tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Raw bus level, 1 = active |
| idle_o | output | 1 | Bus idle after a full inter-frame separation |
| early_idle_o | output | 1 | One-cycle pulse: bus deemed idle by the early rule |
| eod_o | output | 1 | One-cycle pulse: end-of-data gap reached |
| eof_o | output | 1 | One-cycle pulse: end-of-frame gap reached |
| brk_o | output | 1 | One-cycle pulse: break pulse detected |
| bus_rst_o | output | 1 | One-cycle reset request to the surrounding logic |

## Verification
The hardest case to reach is a gap that qualifies for the early rule but comes just after a break, when the rule must stay locked. The stimulus table builds this in order. It sends a long active pulse to trigger a break, then a 29-cycle passive gap that falls between the end-of-frame and inter-frame thresholds, then a rising edge. It then checks that no early pulse appears. The same gap length sent earlier in the table, before the break, must produce the pulse. Every segment length stays at least a cycle away from each threshold, so every pulse falls inside the segment that caused it.

// File: rtl/vpw_idle_pkg.sv
package vpw_idle_pkg;

    // Registered flag state of the detector.
    typedef struct packed {
        logic idle;
        logic early;
        logic eod;
        logic eof;
        logic brk;
        logic rst;
        logic armed;      // early-idle rule enabled
        logic from_fall;  // current passive run began with a falling edge
    } det_state_t;

    localparam det_state_t DET_RESET = '0;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vpw_bus_sync.sv
module vpw_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bus_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], bus_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/vpw_run_timer.sv
module vpw_run_timer #(
    parameter int unsigned SAT = 31,
    localparam int unsigned CW = $clog2(SAT + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          restart_i,
    output logic [CW-1:0] run_q_o,
    output logic [CW-1:0] run_d_o
);
    logic [CW-1:0] run_d, run_q;

    always_comb begin
        if (restart_i)               run_d = CW'(1);
        else if (run_q == CW'(SAT))  run_d = run_q;
        else                         run_d = run_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= '0;
        else         run_q <= run_d;
    end

    assign run_q_o = run_q;
    assign run_d_o = run_d;

endmodule

// File: rtl/vpw_idle_brk.sv
module vpw_idle_brk
    import vpw_idle_pkg::*;
#(
    parameter int unsigned TICK_US   = 125,
    parameter int unsigned EOD_TICKS = 200 * TICK_US,
    parameter int unsigned EOF_TICKS = 280 * TICK_US,
    parameter int unsigned IFS_TICKS = 300 * TICK_US,
    parameter int unsigned BRK_TICKS = 300 * TICK_US,
    parameter int unsigned TOL_TICKS = 4 * TICK_US,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bus_i,
    output logic idle_o,
    output logic early_idle_o,
    output logic eod_o,
    output logic eof_o,
    output logic brk_o,
    output logic bus_rst_o
);
    localparam int unsigned EOD_MIN = EOD_TICKS - TOL_TICKS;
    localparam int unsigned EOF_MIN = EOF_TICKS - TOL_TICKS;
    localparam int unsigned BRK_MIN = BRK_TICKS - TOL_TICKS;
    localparam int unsigned SAT     = umax(IFS_TICKS, umax(BRK_MIN, EOF_MIN)) + 1;
    localparam int unsigned CW      = $clog2(SAT + 1);

    localparam logic [CW-1:0] EOD_C = CW'(EOD_MIN);
    localparam logic [CW-1:0] EOF_C = CW'(EOF_MIN);
    localparam logic [CW-1:0] BRK_C = CW'(BRK_MIN);
    localparam logic [CW-1:0] IFS_C = CW'(IFS_TICKS);

    logic          level, rise, fall, edge_any;
    logic [CW-1:0] run_q, run_d;
    det_state_t    st_d, st_q;

    vpw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .bus_i   (bus_i),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign edge_any = rise | fall;

    vpw_run_timer #(.SAT(SAT)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (edge_any),
        .run_q_o   (run_q),
        .run_d_o   (run_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.early = 1'b0;
        st_d.eod   = 1'b0;
        st_d.eof   = 1'b0;
        st_d.brk   = 1'b0;
        st_d.rst   = 1'b0;

        if (fall) st_d.from_fall = 1'b1;

        // rising edge: run_q still holds the length of the gap just ended
        if (rise) begin
            st_d.idle  = 1'b0;
            st_d.early = st_q.armed && (run_q >= EOF_C) && (run_q < IFS_C);
        end

        // passive run in progress
        if (!level && !edge_any) begin
            if (st_q.from_fall && run_d == EOD_C) st_d.eod = 1'b1;
            if (st_q.from_fall && run_d == EOF_C) st_d.eof = 1'b1;
            if (run_d >= IFS_C) begin
                st_d.idle  = 1'b1;
                st_d.armed = 1'b1;
            end
        end

        // active run in progress: break threshold crossed once
        if (level && !edge_any && run_d == BRK_C) begin
            st_d.brk   = 1'b1;
            st_d.rst   = 1'b1;
            st_d.armed = 1'b0;
            st_d.idle  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= DET_RESET;
        else         st_q <= st_d;
    end

    assign idle_o       = st_q.idle;
    assign early_idle_o = st_q.early;
    assign eod_o        = st_q.eod;
    assign eof_o        = st_q.eof;
    assign brk_o        = st_q.brk;
    assign bus_rst_o    = st_q.rst;

    AST_IDLE_DROPS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise |=> !idle_o);                                          // R2
    AST_EARLY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        early_idle_o |=> !early_idle_o);                            // R3
    AST_BRK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |=> !brk_o);                                          // R6
    AST_BRK_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |-> !idle_o);                                         // R6
    AST_RST_WITH_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |-> bus_rst_o);                                       // R7
    AST_NO_EARLY_AFTER_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |=> !early_idle_o);                                   // R8

endmodule

// File: tb/tb_vpw_idle_brk.sv
`timescale 1ns/1ps
module tb_vpw_idle_brk;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus = 1'b0;
    logic idle, early, eod, eof, brk, brst;

    always #4 clk = ~clk;   // 125 MHz

    vpw_idle_brk #(
        .EOD_TICKS(20), .EOF_TICKS(28), .IFS_TICKS(30),
        .BRK_TICKS(30), .TOL_TICKS(2)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_i(bus),
        .idle_o(idle), .early_idle_o(early), .eod_o(eod),
        .eof_o(eof), .brk_o(brk), .bus_rst_o(brst)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int c_early, c_eod, c_eof, c_brk, c_rst, c_mis;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive a level at the current negedge, then sample the outputs on the next n negedges.
    task automatic hold(input logic lvl, input int n);
        bus = lvl;
        c_early = 0; c_eod = 0; c_eof = 0; c_brk = 0; c_rst = 0; c_mis = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c_early += early; c_eod += eod; c_eof += eof;
            c_brk += brk; c_rst += brst; c_mis += (brk != brst);
        end
    endtask

    typedef struct packed {
        logic       lvl;
        logic [7:0] len;
        logic       idle;
        logic [1:0] early;
        logic [1:0] eod;
        logic [1:0] eof;
        logic [1:0] brk;
    } seg_t;

    localparam seg_t TBL [15] = '{
        '{1'b0, 8'd40, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0},
        '{1'b1, 8'd10, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd24, 1'b0, 2'd0, 2'd1, 2'd0, 2'd0},
        '{1'b1, 8'd10, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd29, 1'b0, 2'd0, 2'd1, 2'd1, 2'd0},
        '{1'b1, 8'd10, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd12, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        '{1'b1, 8'd60, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1},
        '{1'b0, 8'd29, 1'b0, 2'd0, 2'd1, 2'd1, 2'd0},
        '{1'b1, 8'd10, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd33, 1'b1, 2'd0, 2'd1, 2'd1, 2'd0},
        '{1'b1, 8'd5,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd28, 1'b0, 2'd0, 2'd1, 2'd1, 2'd0},
        '{1'b1, 8'd10, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0},
        '{1'b0, 8'd40, 1'b1, 2'd0, 2'd1, 2'd1, 2'd0}
    };

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 reset idle", idle, 0);
        check("R1 reset pulses", early | eod | eof | brk | brst, 0);
        rst_n = 1'b1;

        for (int s = 0; s < 15; s++) begin
            hold(TBL[s].lvl, int'(TBL[s].len));
            check($sformatf("R2 idle seg%0d", s), idle, TBL[s].idle);
            check($sformatf("R3 R8 early seg%0d", s), c_early, TBL[s].early);
            check($sformatf("R4 eod seg%0d", s), c_eod, TBL[s].eod);
            check($sformatf("R5 eof seg%0d", s), c_eof, TBL[s].eof);
            check($sformatf("R6 brk seg%0d", s), c_brk, TBL[s].brk);
            check($sformatf("R7 rst seg%0d", s), c_rst, TBL[s].brk);
            check($sformatf("R7 rst/brk align seg%0d", s), c_mis, 0);
        end

        // R1: reset while idle clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset idle", idle, 0);
        rst_n = 1'b1;

        // R1: no early idle before a full IFS after reset, and no eod without a falling edge
        hold(1'b0, 28);
        check("R1 no idle yet", idle, 0);
        check("R1 no eod from reset", c_eod, 0);
        hold(1'b1, 5);
        check("R1 no early after reset", c_early, 0);

        // R9: eod exactly 20 negedges after the falling edge is driven
        hold(1'b0, 19);
        check("R9 eod not early", c_eod, 0);
        hold(1'b0, 1);
        check("R9 eod on time", c_eod, 1);
        hold(1'b0, 11);
        check("R2 idle not before IFS", idle, 0);
        hold(1'b0, 1);
        check("R2 idle at IFS", idle, 1);

        // R2: idle falls one cycle after the rising edge is detected
        hold(1'b1, 2);
        check("R2 idle holds through sync", idle, 1);
        hold(1'b1, 1);
        check("R2 idle drops", idle, 0);
        check("R3 no early after full IFS", c_early, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule